// File: doc/BRIEF.md
# Configurable 24-pin GPIO port with register access

This block is a general-purpose I/O port of 24 pins behind a byte-wide register interface. The interface has an 8-bit address and 8-bit write and read data, plus single-cycle write and read strobes. Each pin has three configuration bits: direction, drive type and pull select. It also holds one output level bit, and software changes that level only through write-one-to-set and write-one-to-clear registers. The live pin levels are captured every cycle and can be read back. Pins are grouped byte-wise into three lanes, so pin n lives in lane n/8 at bit n%8.

A control register enables the low group (pins 0-15) and the high group (pins 16-23) independently. It also starts a software reset. That reset wipes the port back to all-input, no-pull and holds off further writes for a parameterised number of cycles. Pad behaviour is presented as separate per-pin signals: output enable, output value, open-drain mode, pull enable, pull direction and analog mode. The meaning of the drive-type bit depends on direction. On an output it selects open-drain (1) or push-pull (0). On an input it turns the internal pull on (1) or off (0).

Top module: `gpio_port_regs`

## Requirements
- R1: A read of address 0x00 returns the bitwise complement of the bus address shifted left by one (0x7B for the default address 0x42).
- R2: After reset every register reads 0 and every pad output (oe, out, od, pull_en, pull_up, analog) is 0.
- R3: Direction, type and pull-select bits of pin n are written and read at base+n/8, bit n%8, with bases 0x60, 0x64 and 0x68; a direction bit of 1 makes the pin an output.
- R4: Writing lane k of 0x6C sets the output level of each pin whose data bit is 1, writing lane k of 0x70 clears it, and 0 bits leave the level unchanged.
- R5: An enabled push-pull output (dir 1, type 0) has pad_oe 1, pad_od 0 and pad_out equal to its level.
- R6: An enabled open-drain output (dir 1, type 1) has pad_od 1 and pad_out 0, drives (pad_oe 1) only while its level is 0, and has pull_en and pull_up set exactly when its pull-select bit is 1.
- R7: An enabled input with type 1 has pull_en 1 and pull_up equal to pull-select; with type 0 it has pull_en 0, and pad_analog is 1 exactly when pull-select is 0.
- R8: Control register 0x40 bit 0 enables pins 0-15 and bit 3 enables pins 16-23; a pin in a disabled group ignores writes to its bits and shows all pad outputs at 0 while keeping its stored configuration.
- R9: Writing 0x40 with bit 7 set clears all configuration, level and enable bits at once; bit 7 then reads 1 for reads strobed in the BOOT_CYCLES cycles after the write and 0 afterwards, and every write in that window is ignored.
- R10: Read data appears on rdata in the cycle after the read strobe and holds until the next read; the set and clear registers and any unmapped address read 0.
- R11: A read of 0x10+k returns pin levels of lane k as sampled one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| pin_in | input | 24 | Live pad levels |
| pad_oe | output | 24 | Pad output enable |
| pad_out | output | 24 | Pad output value |
| pad_od | output | 24 | Pad in open-drain mode |
| pad_pull_en | output | 24 | Internal pull active |
| pad_pull_up | output | 24 | Pull direction, 1 = up |
| pad_analog | output | 24 | Input in analog (no pull, not floating) mode |

## Verification
A corrupt configuration bit surfaces on the pad outputs in the very next cycle after the faulty write, because the pad signals are decoded combinationally from the stored bits. It also surfaces in read data one cycle after a read strobe. A wrong lane or bit mapping shows as a pad change on the wrong pin. A reset counter that runs long or short moves the cycle in which bit 7 of the control register drops and in which writes start to take effect again. Ignored writes to a disabled group are only visible after the group is re-enabled, or by reading the register back.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam logic [7:0] A_ID    = 8'h00;
  localparam logic [7:0] A_LEVEL = 8'h10;
  localparam logic [7:0] A_SYS   = 8'h40;
  localparam logic [7:0] A_DIR   = 8'h60;
  localparam logic [7:0] A_TYPE  = 8'h64;
  localparam logic [7:0] A_PULL  = 8'h68;
  localparam logic [7:0] A_SET   = 8'h6C;
  localparam logic [7:0] A_CLR   = 8'h70;

  localparam int SYS_EN_LO = 0;
  localparam int SYS_EN_HI = 3;
  localparam int SYS_RST   = 7;

  function automatic logic lane_hit(input logic [7:0] a, input logic [7:0] base, input int k);
    return a == (base + 8'(k));
  endfunction

  function automatic logic [7:0] chip_id(input logic [6:0] bus_addr);
    return ~{bus_addr, 1'b0};
  endfunction

  function automatic logic [7:0] sys_word(input logic busy, input logic en_lo, input logic en_hi);
    logic [7:0] w;
    w = '0;
    w[SYS_RST]   = busy;
    w[SYS_EN_LO] = en_lo;
    w[SYS_EN_HI] = en_hi;
    return w;
  endfunction

  function automatic logic [7:0] keep_or_write(input logic [7:0] cur, input logic [7:0] d,
                                               input logic [7:0] en);
    return (cur & ~en) | (d & en);
  endfunction
endpackage

// File: rtl/gpio_port_sysctl.sv
module gpio_port_sysctl
  import gpio_port_pkg::*;
#(
  parameter int BOOT_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic       wr_ok,
  output logic       swrst_pulse,
  output logic       busy,
  output logic       en_lo,
  output logic       en_hi
);
  localparam int CW = (BOOT_CYCLES > 1) ? $clog2(BOOT_CYCLES) : 1;

  logic [CW-1:0] cnt;
  logic          sys_wr;
  logic          unused_wbits;

  assign wr_ok        = wr_en & ~busy;
  assign sys_wr       = wr_ok & (addr == A_SYS);
  assign swrst_pulse  = sys_wr & wdata[SYS_RST];
  assign unused_wbits = ^{wdata[6:4], wdata[2:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      en_lo <= 1'b0;
      en_hi <= 1'b0;
    end else if (swrst_pulse) begin
      busy  <= 1'b1;
      cnt   <= CW'(BOOT_CYCLES - 1);
      en_lo <= 1'b0;
      en_hi <= 1'b0;
    end else begin
      if (sys_wr) begin
        en_lo <= wdata[SYS_EN_LO];
        en_hi <= wdata[SYS_EN_HI];
      end
      if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  // R9
  rst_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_pulse |=> busy && !en_lo && !en_hi);
  // R9
  busy_blocks_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ok);
endmodule

// File: rtl/gpio_port_cfg.sv
module gpio_port_cfg
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 wr,
  input  logic [7:0]           addr,
  input  logic [7:0]           wdata,
  input  logic [PIN_COUNT-1:0] pin_en,
  output logic [PIN_COUNT-1:0] dir,
  output logic [PIN_COUNT-1:0] typ,
  output logic [PIN_COUNT-1:0] pul,
  output logic [PIN_COUNT-1:0] lvl
);
  localparam int LANES = PIN_COUNT / 8;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [7:0] dir_r, typ_r, pul_r, lvl_r, en;
    assign en = pin_en[8*k +: 8];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_r <= '0; typ_r <= '0; pul_r <= '0; lvl_r <= '0;
      end else if (clear) begin
        dir_r <= '0; typ_r <= '0; pul_r <= '0; lvl_r <= '0;
      end else if (wr) begin
        if (lane_hit(addr, A_DIR, k))  dir_r <= keep_or_write(dir_r, wdata, en);
        if (lane_hit(addr, A_TYPE, k)) typ_r <= keep_or_write(typ_r, wdata, en);
        if (lane_hit(addr, A_PULL, k)) pul_r <= keep_or_write(pul_r, wdata, en);
        if (lane_hit(addr, A_SET, k))  lvl_r <= lvl_r | (wdata & en);
        if (lane_hit(addr, A_CLR, k))  lvl_r <= lvl_r & ~(wdata & en);
      end
    end

    assign dir[8*k +: 8] = dir_r;
    assign typ[8*k +: 8] = typ_r;
    assign pul[8*k +: 8] = pul_r;
    assign lvl[8*k +: 8] = lvl_r;
  end

  // R8
  dis_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clear) |-> ((dir ^ $past(dir)) & ~$past(pin_en)) == '0);
  // R8
  dis_lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clear) |-> ((lvl ^ $past(lvl)) & ~$past(pin_en)) == '0);
  // R9
  clear_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (dir | typ | pul | lvl) == '0);
endmodule

// File: rtl/gpio_port_pad.sv
module gpio_port_pad #(
  parameter int PIN_COUNT = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIN_COUNT-1:0] pin_en,
  input  logic [PIN_COUNT-1:0] dir,
  input  logic [PIN_COUNT-1:0] typ,
  input  logic [PIN_COUNT-1:0] pul,
  input  logic [PIN_COUNT-1:0] lvl,
  output logic [PIN_COUNT-1:0] pad_oe,
  output logic [PIN_COUNT-1:0] pad_out,
  output logic [PIN_COUNT-1:0] pad_od,
  output logic [PIN_COUNT-1:0] pad_pull_en,
  output logic [PIN_COUNT-1:0] pad_pull_up,
  output logic [PIN_COUNT-1:0] pad_analog
);
  for (genvar n = 0; n < PIN_COUNT; n++) begin : g_pin
    logic is_out;
    assign is_out         = pin_en[n] & dir[n];
    assign pad_od[n]      = is_out & typ[n];
    assign pad_oe[n]      = is_out & (~typ[n] | ~lvl[n]);
    assign pad_out[n]     = is_out & ~typ[n] & lvl[n];
    assign pad_pull_en[n] = pin_en[n] & typ[n] & (~dir[n] | pul[n]);
    assign pad_pull_up[n] = pin_en[n] & typ[n] & pul[n];
    assign pad_analog[n]  = pin_en[n] & ~dir[n] & ~typ[n] & ~pul[n];
  end

  // R6
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_od & pad_out) == '0);
  // R8
  dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_od | pad_pull_en | pad_analog) & ~pin_en) == '0);
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int         PIN_COUNT   = 24,
  parameter int         LOW_GROUP   = 16,
  parameter int         BOOT_CYCLES = 16,
  parameter logic [6:0] BUS_ADDR    = 7'h42
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [7:0]           addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  input  logic [PIN_COUNT-1:0] pin_in,
  output logic [PIN_COUNT-1:0] pad_oe,
  output logic [PIN_COUNT-1:0] pad_out,
  output logic [PIN_COUNT-1:0] pad_od,
  output logic [PIN_COUNT-1:0] pad_pull_en,
  output logic [PIN_COUNT-1:0] pad_pull_up,
  output logic [PIN_COUNT-1:0] pad_analog
);
  localparam int LANES = PIN_COUNT / 8;

  logic                 wr_ok, swrst_pulse, busy, en_lo, en_hi;
  logic [PIN_COUNT-1:0] pin_en, dir, typ, pul, lvl, pin_q;
  logic [7:0]           rd_mux;

  gpio_port_sysctl #(.BOOT_CYCLES(BOOT_CYCLES)) u_sys (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .wr_ok(wr_ok), .swrst_pulse(swrst_pulse), .busy(busy),
    .en_lo(en_lo), .en_hi(en_hi)
  );

  for (genvar n = 0; n < PIN_COUNT; n++) begin : g_en
    if (n < LOW_GROUP) begin : g_lo
      assign pin_en[n] = en_lo;
    end else begin : g_hi
      assign pin_en[n] = en_hi;
    end
  end

  gpio_port_cfg #(.PIN_COUNT(PIN_COUNT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .clear(swrst_pulse), .wr(wr_ok),
    .addr(addr), .wdata(wdata), .pin_en(pin_en),
    .dir(dir), .typ(typ), .pul(pul), .lvl(lvl)
  );

  gpio_port_pad #(.PIN_COUNT(PIN_COUNT)) u_pad (
    .clk(clk), .rst_n(rst_n), .pin_en(pin_en),
    .dir(dir), .typ(typ), .pul(pul), .lvl(lvl),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od),
    .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up), .pad_analog(pad_analog)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_in;
  end

  always_comb begin
    rd_mux = '0;
    if (addr == A_ID)  rd_mux = chip_id(BUS_ADDR);
    if (addr == A_SYS) rd_mux = sys_word(busy, en_lo, en_hi);
    for (int k = 0; k < LANES; k++) begin
      if (lane_hit(addr, A_LEVEL, k)) rd_mux = pin_q[8*k +: 8];
      if (lane_hit(addr, A_DIR, k))   rd_mux = dir[8*k +: 8];
      if (lane_hit(addr, A_TYPE, k))  rd_mux = typ[8*k +: 8];
      if (lane_hit(addr, A_PULL, k))  rd_mux = pul[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  // R1
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_ID) |=> rdata == ~{BUS_ADDR, 1'b0});
endmodule

// File: tb/gpio_port_regs_test.sv
module gpio_port_regs_test;
  localparam int BOOT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [7:0]  rdata;
  logic [23:0] pin_in = '0;
  logic [23:0] pad_oe, pad_out, pad_od, pad_pull_en, pad_pull_up, pad_analog;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_port_regs #(.BOOT_CYCLES(BOOT)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_od(pad_od), .pad_pull_en(pad_pull_en),
    .pad_pull_up(pad_pull_up), .pad_analog(pad_analog)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    do_reset();
    check("R2 pads", {8'h0, pad_oe | pad_out | pad_od | pad_pull_en | pad_pull_up | pad_analog}, 0);
    rd(8'h40, d); check("R2 sys", d, 0);
    rd(8'h61, d); check("R2 dir", d, 0);
    rd(8'h66, d); check("R2 type", d, 0);
  endtask

  task automatic t_id();
    logic [7:0] d;
    rd(8'h00, d); check("R1 id", d, 8'h7B);
  endtask

  task automatic t_map();
    logic [7:0] d;
    do_reset(); wr(8'h40, 8'h09);
    wr(8'h61, 8'h20);                        // pin 13 output
    rd(8'h61, d); check("R3 dir lane1", d, 8'h20);
    check("R3 pad pin13", {8'h0, pad_oe}, 32'h0000_2000);
    wr(8'h64, 8'h81); rd(8'h64, d); check("R3 type lane0", d, 8'h81);
    wr(8'h6A, 8'h40); rd(8'h6A, d); check("R3 pull lane2", d, 8'h40);
  endtask

  task automatic t_setclr();
    do_reset(); wr(8'h40, 8'h09); wr(8'h60, 8'hFF);
    wr(8'h6C, 8'hA5); check("R4 set", pad_out[7:0], 8'hA5);
    wr(8'h70, 8'h21); check("R4 clear", pad_out[7:0], 8'h84);
    wr(8'h6C, 8'h02); check("R4 set keeps others", pad_out[7:0], 8'h86);
    wr(8'h70, 8'h00); check("R4 zero clear no effect", pad_out[7:0], 8'h86);
  endtask

  task automatic t_pushpull();
    do_reset(); wr(8'h40, 8'h09); wr(8'h62, 8'h10);   // pin 20
    check("R5 oe low level", {pad_oe[20], pad_out[20], pad_od[20]}, 3'b100);
    wr(8'h6E, 8'h10);
    check("R5 high level", {pad_oe[20], pad_out[20], pad_od[20]}, 3'b110);
    wr(8'h72, 8'h10);
    check("R5 cleared", {pad_oe[20], pad_out[20]}, 2'b10);
  endtask

  task automatic t_opendrain();
    do_reset(); wr(8'h40, 8'h09);
    wr(8'h61, 8'h02); wr(8'h65, 8'h02);                  // pin 9 open-drain
    check("R6 od no pull", {pad_oe[9], pad_out[9], pad_od[9], pad_pull_en[9]}, 4'b1010);
    wr(8'h69, 8'h02);
    check("R6 od pull-up", {pad_pull_en[9], pad_pull_up[9]}, 2'b11);
    wr(8'h6D, 8'h02);
    check("R6 od released", {pad_oe[9], pad_out[9], pad_od[9]}, 3'b001);
  endtask

  task automatic t_input_pulls();
    do_reset(); wr(8'h40, 8'h09);
    wr(8'h66, 8'h03); wr(8'h6A, 8'h05);
    check("R7 pull_en", pad_pull_en[23:16], 8'h03);
    check("R7 pull_up", pad_pull_up[23:16], 8'h01);
    check("R7 analog", pad_analog[23:16], 8'hF8);
    check("R7 no drive", pad_oe[23:16], 8'h00);
  endtask

  task automatic t_groups();
    logic [7:0] d;
    do_reset();
    wr(8'h60, 8'hFF); rd(8'h60, d); check("R8 both off write ignored", d, 0);
    wr(8'h40, 8'h01);
    wr(8'h62, 8'hFF); rd(8'h62, d); check("R8 hi off write ignored", d, 0);
    wr(8'h60, 8'hFF); rd(8'h60, d); check("R8 lo on write", d, 8'hFF);
    check("R8 lo pads drive", pad_oe[15:0], 16'h00FF);
    wr(8'h40, 8'h08);
    check("R8 lo disabled quiet", pad_oe[15:0] | pad_analog[15:0], 16'h0000);
    check("R8 hi enabled analog", pad_analog[23:16], 8'hFF);
    wr(8'h60, 8'h00); wr(8'h40, 8'h09);
    rd(8'h60, d); check("R8 stored config kept", d, 8'hFF);
    rd(8'h40, d); check("R8 sys readback", d, 8'h09);
  endtask

  task automatic t_swrst();
    logic [7:0] d;
    do_reset(); wr(8'h40, 8'h09); wr(8'h60, 8'h0F); wr(8'h6C, 8'h03);
    wr(8'h40, 8'h89);
    check("R9 pads cleared", {8'h0, pad_oe | pad_out | pad_analog}, 0);
    wr(8'h61, 8'hFF);                          // during busy
    repeat (BOOT - 2) @(negedge clk);
    rd(8'h40, d); check("R9 busy last cycle", d, 8'h80);
    rd(8'h40, d); check("R9 busy cleared", d, 8'h00);
    wr(8'h40, 8'h09);
    rd(8'h60, d); check("R9 dir wiped", d, 0);
    rd(8'h61, d); check("R9 write while busy ignored", d, 0);
    wr(8'h60, 8'h01);
    check("R9 level wiped", pad_out[0], 1'b0);
  endtask

  task automatic t_readzero();
    logic [7:0] d;
    do_reset(); wr(8'h40, 8'h09); wr(8'h60, 8'hFF); wr(8'h6C, 8'hFF);
    rd(8'h6C, d); check("R10 set reads 0", d, 0);
    rd(8'h70, d); check("R10 clear reads 0", d, 0);
    rd(8'h63, d); check("R10 gap reads 0", d, 0);
    rd(8'h60, d);
    addr = 8'h6A; repeat (3) @(negedge clk);
    check("R10 rdata holds", rdata, 8'hFF);
  endtask

  task automatic t_level();
    logic [7:0] d;
    do_reset();
    pin_in = 24'h5A_C3_81;
    rd(8'h10, d); check("R11 not yet sampled", d, 8'h00);
    rd(8'h10, d); check("R11 lane0", d, 8'h81);
    rd(8'h11, d); check("R11 lane1", d, 8'hC3);
    rd(8'h12, d); check("R11 lane2", d, 8'h5A);
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_id();
    t_map();
    t_setclr();
    t_pushpull();
    t_opendrain();
    t_input_pulls();
    t_groups();
    t_swrst();
    t_readzero();
    t_level();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule